// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receive Channel

This block receives character-framed asynchronous serial data on a single line. A programmable divider produces a sampling tick, and every bit period spans a fixed number of ticks (16 by default). The receiver finds the start bit, confirms it, and samples each later bit at its centre. Each character is stored in a receive queue together with its own parity-error and framing-error flags. The format is chosen on quasi-static inputs: 7 or 8 data bits, 1 or 2 stop bits, and parity that is off, even or odd. Every combination of these settings is supported.

A consumer drains the queue with a read strobe. The oldest entry is always visible on the read-data outputs. When a character completes while the queue is already full, that character is dropped and a sticky overrun flag is set. A break is the line stuck low after a character that ended with a low stop bit. The block raises a break flag for it and then holds off further reception until the line has idled high for a full bit time.

Top module: `async_rx_channel`

## Requirements
- R1: The sampling tick repeats every `divisor_i`+1 clock cycles, and one bit period is 16 ticks. Characters are received correctly at different divisor values.
- R2: Data bits arrive least significant bit first. With `len8_i`=1 the character has 8 data bits. With `len8_i`=0 it has 7 data bits and bit 7 of `rd_data_o` reads 0.
- R3: All combinations of data length, stop length (`stop2_i`=1 means two stop bits), and parity (`par_en_i`=0 none; `par_en_i`=1 with `par_odd_i`=0 even, `par_odd_i`=1 odd) are received without error flags when the frame is well formed.
- R4: With parity enabled, `rd_perr_o` is 1 for a character whose parity bit does not give the selected even or odd count of ones over data plus parity.
- R5: A character with any stop bit sampled low is stored with `rd_ferr_o`=1.
- R6: The queue holds 16 characters in arrival order. `level_o` gives the count, `empty_o` is 1 at count 0, and `full_o` is 1 at count 16. A read strobe removes the oldest entry.
- R7: A character that completes while the queue is full is discarded and the stored entries are kept. `ovr_o` then stays 1 until `ovr_clr_i` is pulsed.
- R8: After a framing error, if the line stays low for one full frame time, `brk_o` becomes 1. If the line returns high sooner, no break is flagged and no further character is stored from the low period.
- R9: After a break, `brk_o` clears and start detection resumes only once the line has been high for one continuous bit time. A shorter high period leaves `brk_o` at 1.
- R10: A low pulse on the line that has ended by the middle of the start bit is ignored and stores nothing.
- R11: After reset the queue is empty (`level_o`=0, `empty_o`=1, `full_o`=0), and `brk_o` and `ovr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idles high |
| len8_i | input | 1 | 1: 8 data bits, 0: 7 data bits |
| stop2_i | input | 1 | 1: two stop bits, 0: one |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| divisor_i | input | DIV_W | Tick period minus one, in clock cycles |
| rd_i | input | 1 | Read strobe, pops the oldest entry |
| ovr_clr_i | input | 1 | Clears the sticky overrun flag |
| rd_data_o | output | 8 | Oldest character (0 when empty) |
| rd_perr_o | output | 1 | Parity error of the oldest character |
| rd_ferr_o | output | 1 | Framing error of the oldest character |
| brk_o | output | 1 | Break condition on the line |
| ovr_o | output | 1 | Sticky overrun flag |
| level_o | output | LW | Number of stored characters |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue full |

## Verification
The hardest state to reach from the ports is the break path followed by its holdoff. The stimulus first sends a character with a forced-low stop bit. It then holds the line low for more than a frame time, and only after that releases it high for less than a bit time before the full release. A separate run lets the line return high right after the bad stop bit, which shows that a framing error alone does not raise a break. Overrun needs seventeen back-to-back characters with no reads, followed by a drain that proves the first sixteen survived unchanged.

// File: rtl/arx_pkg.sv
package arx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_BRKW,
      ST_HOLD
   } rx_state_e;

   typedef struct packed {
      logic       ferr;
      logic       perr;
      logic [7:0] data;
   } rx_char_t;

   localparam int CHAR_W   = $bits(rx_char_t);
   localparam int MAX_BITS = 12;
endpackage

// File: rtl/arx_sync.sv
module arx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/arx_baud_gen.sv
module arx_baud_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt >= divisor) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end
endmodule

// File: rtl/arx_deframer.sv
module arx_deframer
   import arx_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     tick,
   input  logic     rx,
   input  logic     len8,
   input  logic     stop2,
   input  logic     par_en,
   input  logic     par_odd,
   output logic     push,
   output rx_char_t push_char,
   output logic     brk
);
   localparam int CW = $clog2(OVS);
   localparam int BW = $clog2(MAX_BITS * OVS + 1);
   localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] LAST = CW'(OVS - 1);
   localparam logic [BW-1:0] BIT_T = BW'(OVS - 1);

   rx_state_e     state;
   logic [CW-1:0] tcnt;
   logic [3:0]    bidx;
   logic [7:0]    shreg;
   logic          perr_q;
   logic          ferr_q;
   logic          second;
   logic [BW-1:0] bcnt;

   logic [3:0]    frame_bits;
   logic [BW-1:0] frame_ticks;
   logic [7:0]    data_now;
   logic [3:0]    last_bit;
   logic          ferr_now;

   always_comb begin
      frame_bits  = 4'd1 + (len8 ? 4'd8 : 4'd7) + {3'b000, par_en} + (stop2 ? 4'd2 : 4'd1);
      frame_ticks = BW'(frame_bits) * BW'(OVS);
      data_now    = len8 ? shreg : {1'b0, shreg[7:1]};
      last_bit    = len8 ? 4'd7 : 4'd6;
      ferr_now    = ferr_q | ~rx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         tcnt      <= '0;
         bidx      <= '0;
         shreg     <= '0;
         perr_q    <= 1'b0;
         ferr_q    <= 1'b0;
         second    <= 1'b0;
         bcnt      <= '0;
         brk       <= 1'b0;
         push      <= 1'b0;
         push_char <= '0;
      end else begin
         push <= 1'b0;
         if (tick) begin
            case (state)
               ST_IDLE: begin
                  if (!rx) begin
                     state <= ST_START;
                     tcnt  <= '0;
                  end
               end
               ST_START: begin
                  if (tcnt == MID) begin
                     tcnt <= '0;
                     if (rx) begin
                        state <= ST_IDLE;
                     end else begin
                        state  <= ST_DATA;
                        bidx   <= '0;
                        perr_q <= 1'b0;
                        ferr_q <= 1'b0;
                        second <= 1'b0;
                     end
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               ST_DATA: begin
                  if (tcnt == LAST) begin
                     tcnt  <= '0;
                     shreg <= {rx, shreg[7:1]};
                     if (bidx == last_bit) state <= par_en ? ST_PAR : ST_STOP;
                     else                  bidx  <= bidx + 1'b1;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               ST_PAR: begin
                  if (tcnt == LAST) begin
                     tcnt   <= '0;
                     perr_q <= (^data_now) ^ rx ^ par_odd;
                     state  <= ST_STOP;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               ST_STOP: begin
                  if (tcnt == LAST) begin
                     tcnt <= '0;
                     if (stop2 && !second) begin
                        second <= 1'b1;
                        if (!rx) ferr_q <= 1'b1;
                     end else begin
                        push           <= 1'b1;
                        push_char.ferr <= ferr_now;
                        push_char.perr <= perr_q;
                        push_char.data <= data_now;
                        bcnt           <= '0;
                        state          <= ferr_now ? ST_BRKW : ST_IDLE;
                     end
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               ST_BRKW: begin
                  if (rx) begin
                     state <= ST_IDLE;
                  end else if (bcnt == frame_ticks - 1'b1) begin
                     brk   <= 1'b1;
                     bcnt  <= '0;
                     state <= ST_HOLD;
                  end else begin
                     bcnt <= bcnt + 1'b1;
                  end
               end
               ST_HOLD: begin
                  if (!rx) begin
                     bcnt <= '0;
                  end else if (bcnt == BIT_T) begin
                     brk   <= 1'b0;
                     bcnt  <= '0;
                     state <= ST_IDLE;
                  end else begin
                     bcnt <= bcnt + 1'b1;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/arx_fifo.sv
module arx_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 10,
   parameter int LW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [W-1:0]  wdata,
   input  logic          rd,
   output logic [W-1:0]  rdata,
   output logic [LW-1:0] level,
   output logic          empty,
   output logic          full,
   output logic          drop
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [LW-1:0] CAP = LW'(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr;
   logic [AW-1:0] rptr;
   logic [LW-1:0] cnt;
   logic          do_wr;
   logic          do_rd;

   always_comb begin
      full  = (cnt == CAP);
      empty = (cnt == '0);
      do_wr = wr & ~full;
      do_rd = rd & ~empty;
      drop  = wr & full;
      level = cnt;
      rdata = mem[rptr];
   end

   always_ff @(posedge clk) begin
      if (do_wr) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_wr) wptr <= wptr + 1'b1;
         if (do_rd) rptr <= rptr + 1'b1;
         case ({do_wr, do_rd})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/async_rx_channel.sv
module async_rx_channel
   import arx_pkg::*;
#(
   parameter int DEPTH       = 16,
   parameter int OVS         = 16,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int LW         = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_i,
   input  logic             len8_i,
   input  logic             stop2_i,
   input  logic             par_en_i,
   input  logic             par_odd_i,
   input  logic [DIV_W-1:0] divisor_i,
   input  logic             rd_i,
   input  logic             ovr_clr_i,
   output logic [7:0]       rd_data_o,
   output logic             rd_perr_o,
   output logic             rd_ferr_o,
   output logic             brk_o,
   output logic             ovr_o,
   output logic [LW-1:0]    level_o,
   output logic             empty_o,
   output logic             full_o
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("OVS must be a power of two of at least 4");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
   endgenerate

   logic     rx_s;
   logic     tick;
   logic     push;
   rx_char_t push_char;
   rx_char_t head;
   logic     drop;
   logic     ovr_q;

   arx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rx_i),
      .q     (rx_s)
   );

   arx_baud_gen #(.DIV_W(DIV_W)) u_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .divisor (divisor_i),
      .tick    (tick)
   );

   arx_deframer #(.OVS(OVS)) u_frm (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .rx        (rx_s),
      .len8      (len8_i),
      .stop2     (stop2_i),
      .par_en    (par_en_i),
      .par_odd   (par_odd_i),
      .push      (push),
      .push_char (push_char),
      .brk       (brk_o)
   );

   arx_fifo #(.DEPTH(DEPTH), .W(CHAR_W), .LW(LW)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (push),
      .wdata (push_char),
      .rd    (rd_i),
      .rdata (head),
      .level (level_o),
      .empty (empty_o),
      .full  (full_o),
      .drop  (drop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ovr_q <= 1'b0;
      else if (drop)      ovr_q <= 1'b1;
      else if (ovr_clr_i) ovr_q <= 1'b0;
   end

   always_comb begin
      ovr_o     = ovr_q;
      rd_data_o = empty_o ? 8'h00 : head.data;
      rd_perr_o = ~empty_o & head.perr;
      rd_ferr_o = ~empty_o & head.ferr;
   end
endmodule

// File: rtl/arx_rx_checker.sv
module arx_rx_checker #(
   parameter int DEPTH = 16,
   parameter int LW    = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_i,
   input logic          ovr_clr_i,
   input logic          ovr_o,
   input logic          full_o,
   input logic [LW-1:0] level_o
);
   a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      int'(level_o) <= DEPTH);

   a_r6_level_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (int'(level_o) - int'($past(level_o)) <= 1) &&
               (int'($past(level_o)) - int'(level_o) <= 1));

   a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      full_o && !rd_i |=> full_o);

   a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_o && !ovr_clr_i |=> ovr_o);

   a_r7_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_o) |-> $past(full_o));

   a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_clr_i && !full_o |=> !ovr_o);
endmodule

bind async_rx_channel arx_rx_checker #(.DEPTH(DEPTH), .LW(LW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_i      (rd_i),
   .ovr_clr_i (ovr_clr_i),
   .ovr_o     (ovr_o),
   .full_o    (full_o),
   .level_o   (level_o)
);

// File: tb/tb_async_rx_channel.sv
module tb_async_rx_channel;
   localparam int DEPTH = 16;
   localparam int OVS   = 16;
   localparam int DIV_W = 8;
   localparam int LW    = $clog2(DEPTH + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rx = 1'b1;
   logic             len8 = 1'b1;
   logic             stop2 = 1'b0;
   logic             pen = 1'b0;
   logic             podd = 1'b0;
   logic [DIV_W-1:0] div = 8'd1;
   logic             rd = 1'b0;
   logic             oclr = 1'b0;
   logic [7:0]       rdata;
   logic             perr, ferr, brk, ovr, empty, full;
   logic [LW-1:0]    level;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   async_rx_channel #(.DEPTH(DEPTH), .OVS(OVS), .DIV_W(DIV_W)) dut (
      .clk(clk), .rst_n(rst_n), .rx_i(rx), .len8_i(len8), .stop2_i(stop2),
      .par_en_i(pen), .par_odd_i(podd), .divisor_i(div), .rd_i(rd),
      .ovr_clr_i(oclr), .rd_data_o(rdata), .rd_perr_o(perr), .rd_ferr_o(ferr),
      .brk_o(brk), .ovr_o(ovr), .level_o(level), .empty_o(empty), .full_o(full)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic drive(input logic v, input int n);
      rx = v;
      repeat (n) @(negedge clk);
   endtask

   function automatic int bitclk();
      return OVS * (int'(div) + 1);
   endfunction

   task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
      int  bc;
      logic p;
      bc = bitclk();
      p  = (len8 ? ^d : ^d[6:0]) ^ podd ^ bad_par;
      drive(1'b0, bc);
      for (int i = 0; i < (len8 ? 8 : 7); i++) drive(d[i], bc);
      if (pen) drive(p, bc);
      drive(~bad_stop, bc);
      if (stop2) drive(~bad_stop, bc);
   endtask

   task automatic pop();
      rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
   endtask

   function automatic int exp_data(input logic [7:0] d);
      return len8 ? int'(d) : int'({1'b0, d[6:0]});
   endfunction

   task automatic set_fmt(input int f);
      len8  = f[0];
      stop2 = f[1];
      pen   = (f / 4) != 0;
      podd  = (f / 4) == 2;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         finish_run();
      end
   end

   initial begin
      logic [7:0] d;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11 level", int'(level), 0);
      check("R11 empty", int'(empty), 1);
      check("R11 full", int'(full), 0);
      check("R11 brk", int'(brk), 0);
      check("R11 ovr", int'(ovr), 0);

      // R1 R2 R3 sweep: two divisors, every format, three bytes
      for (int dv = 1; dv <= 3; dv += 2) begin
         div = DIV_W'(dv);
         for (int f = 0; f < 12; f++) begin
            set_fmt(f);
            for (int k = 0; k < 3; k++) begin
               d = (k == 0) ? 8'hFF : (k == 1) ? (8'hA5 ^ 8'(f)) : (8'h3C + 8'(f * 7));
               send_frame(d, 1'b0, 1'b0);
               drive(1'b1, bitclk());
               check("R1 R3 level", int'(level), 1);
               check("R2 R3 data", int'(rdata), exp_data(d));
               check("R3 perr", int'(perr), 0);
               check("R3 ferr", int'(ferr), 0);
               pop();
            end
         end
      end
      div = 8'd1;

      // R4 parity errors, even and odd
      set_fmt(4 + 1);
      send_frame(8'h96, 1'b1, 1'b0);
      drive(1'b1, bitclk());
      check("R4 perr even", int'(perr), 1);
      check("R4 data", int'(rdata), 8'h96);
      pop();
      set_fmt(8 + 2);
      send_frame(8'hD3, 1'b1, 1'b0);
      drive(1'b1, bitclk());
      check("R4 perr odd 7bit", int'(perr), 1);
      check("R2 7bit msb", int'(rdata), 8'h53);
      pop();

      // R5 R8 framing error, line back high: no break
      set_fmt(1);
      send_frame(8'h21, 1'b0, 1'b1);
      drive(1'b1, 20 * bitclk());
      check("R5 ferr", int'(ferr), 1);
      check("R8 no break", int'(brk), 0);
      check("R8 one entry", int'(level), 1);
      pop();

      // R8 R9 break and holdoff
      send_frame(8'h00, 1'b0, 1'b1);
      drive(1'b0, 14 * bitclk());
      check("R8 break", int'(brk), 1);
      check("R8 single entry", int'(level), 1);
      check("R5 break ferr", int'(ferr), 1);
      pop();
      drive(1'b1, bitclk() / 2);
      check("R9 short high keeps brk", int'(brk), 1);
      drive(1'b0, bitclk());
      drive(1'b1, bitclk() / 2 + bitclk() / 4);
      check("R9 restart count", int'(brk), 1);
      drive(1'b1, 2 * bitclk());
      check("R9 brk cleared", int'(brk), 0);
      check("R9 nothing stored", int'(level), 0);
      send_frame(8'h7E, 1'b0, 1'b0);
      drive(1'b1, bitclk());
      check("R9 resume data", int'(rdata), 8'h7E);
      pop();

      // R10 short low glitch
      drive(1'b0, 4 * (int'(div) + 1));
      drive(1'b1, 3 * bitclk());
      check("R10 glitch ignored", int'(level), 0);

      // R6 R7 fill, overrun, drain
      for (int i = 0; i < 17; i++) send_frame(8'(i * 13 + 1), 1'b0, 1'b0);
      drive(1'b1, bitclk());
      check("R6 full", int'(full), 1);
      check("R6 level", int'(level), 16);
      check("R7 ovr set", int'(ovr), 1);
      for (int i = 0; i < 16; i++) begin
         check("R6 R7 order", int'(rdata), (i * 13 + 1) & 8'hFF);
         pop();
      end
      check("R6 empty", int'(empty), 1);
      check("R7 sticky", int'(ovr), 1);
      oclr = 1'b1;
      @(negedge clk);
      oclr = 1'b0;
      check("R7 cleared", int'(ovr), 0);

      done = 1'b1;
      finish_run();
   end
endmodule